// File: doc/BRIEF.md
# Multicycle 16-bit Register-Machine Processor

This block is a compact processor core that runs 16-bit instructions from one shared memory holding both program and data. A control sequencer walks every instruction through a fetch step, a decode step and an execute step, and loads and stores take one further memory step. One arithmetic unit serves both the datapath and the program counter. That unit produces the incremented program counter during fetch, and the branch target and effective address during execute.

The core has eight 16-bit general registers, where register 0 always reads as zero, plus an instruction register and a program counter. A 255-word internal memory is filled through a load port while the core is held in reset. The top memory word, at index 254, is driven continuously to a display output. Once the core executes a halt instruction it stops fetching and holds its state until the next reset.

Top module: `mcpu16_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` reads 0 and `halted_o` reads 0. The first rising edge after release performs a fetch from word 0.
- R2: A fetch loads the instruction register from the memory word addressed by the PC and writes PC+1 back to the PC. The increment comes from the shared arithmetic unit.
- R3: Register-format instructions, addi, beq and jump each take three cycles (fetch, decode, execute). Loads and stores take four cycles because a memory step follows execute.
- R4: Instruction fields are op = bits 15:13, rs = 12:10, rt = 9:7, rd = 6:4, funct = 3:0, offset = 6:0 and target = 12:0.
- R5: For op 0, funct selects the result written to rd: 0 gives rs+rt, 1 gives rs-rt, 2 gives rs AND rt, 3 gives rs OR rt, and 4 gives 1 if rs < rt as signed 16-bit values, else 0. Any other funct value writes nothing.
- R6: Op 1 (load) writes rt with the memory word at rs+offset. Op 2 (store) writes rt into the memory word at rs+offset. Addresses of 255 or above read as zero, and stores to them are dropped.
- R7: Op 3 (beq) sets the PC to the incremented PC plus offset when rs equals rt, and otherwise leaves the PC unchanged. Op 5 (jump) loads the PC with the zero-extended 13-bit target.
- R8: Op 7 (halt) raises `halted_o` after its execute step. From then on the PC, the registers and memory are frozen until reset.
- R9: The 7-bit offset is sign-extended to 16 bits for load, store, beq and addi. Op 4 (addi) writes rt with rs plus that extended offset.
- R10: Register 0 reads as zero, and any write to it is discarded.
- R11: `display_o` always equals memory word 254.
- R12: A load-port write (`prog_we`) to an index below 255 updates memory on the rising edge. In a cycle where the load port writes, any store from the core is dropped.
- R13: Op 6 is treated as a no-operation that returns to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Memory load-port write strobe |
| prog_addr | input | 8 | Memory load-port word index |
| prog_data | input | 16 | Memory load-port write data |
| display_o | output | 16 | Contents of memory word 254 |
| pc_o | output | 16 | Current program counter |
| halted_o | output | 1 | High once a halt instruction has executed |

## Verification
The assertions assume that memory was fully written through the load port before execution depends on it, so that the instruction register and display never hold unknown values. They also assume that the load port is used only while the core is held in reset, or after it has halted. The bench respects both assumptions: it writes all 255 words during reset and touches the load port again only after `halted_o` rises. The program it loads avoids relying on any memory word it has not explicitly defined.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

  localparam int XLEN = 16;
  localparam int NREG = 8;
  localparam int RAW  = $clog2(NREG);
  localparam int OFW  = 7;
  localparam int TGW  = 13;

  localparam logic [2:0] OP_RTYPE = 3'd0;
  localparam logic [2:0] OP_LOAD  = 3'd1;
  localparam logic [2:0] OP_STORE = 3'd2;
  localparam logic [2:0] OP_BEQ   = 3'd3;
  localparam logic [2:0] OP_ADDI  = 3'd4;
  localparam logic [2:0] OP_JUMP  = 3'd5;
  localparam logic [2:0] OP_HALT  = 3'd7;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_HALT
  } state_e;

  typedef enum logic [2:0] {
    AL_ADD, AL_SUB, AL_AND, AL_OR, AL_SLT
  } alu_op_e;

  typedef enum logic [1:0] {
    BS_REG, BS_ONE, BS_IMM
  } bsel_e;

  typedef struct packed {
    logic    ir_ld;
    logic    pc_ld;
    logic    pc_jump;
    logic    ab_ld;
    logic    ea_ld;
    logic    rf_we;
    logic    rf_dst_rd;
    logic    rf_from_mem;
    logic    st_we;
    logic    addr_ea;
    logic    a_is_pc;
    bsel_e   bsel;
    alu_op_e aop;
  } ctrl_t;

  // instruction field extraction
  function automatic logic [2:0] f_op(input logic [XLEN-1:0] ir);
    return ir[15:13];
  endfunction
  function automatic logic [RAW-1:0] f_rs(input logic [XLEN-1:0] ir);
    return ir[12:10];
  endfunction
  function automatic logic [RAW-1:0] f_rt(input logic [XLEN-1:0] ir);
    return ir[9:7];
  endfunction
  function automatic logic [RAW-1:0] f_rd(input logic [XLEN-1:0] ir);
    return ir[6:4];
  endfunction
  function automatic logic [3:0] f_fn(input logic [XLEN-1:0] ir);
    return ir[3:0];
  endfunction
  function automatic logic [OFW-1:0] f_off(input logic [XLEN-1:0] ir);
    return ir[OFW-1:0];
  endfunction
  function automatic logic [TGW-1:0] f_tgt(input logic [XLEN-1:0] ir);
    return ir[TGW-1:0];
  endfunction

  function automatic logic [XLEN-1:0] sext_off(input logic [OFW-1:0] off);
    return {{(XLEN-OFW){off[OFW-1]}}, off};
  endfunction

  function automatic logic funct_valid(input logic [3:0] fn);
    return fn <= 4'd4;
  endfunction

  function automatic alu_op_e funct_to_alu(input logic [3:0] fn);
    case (fn)
      4'd1:    return AL_SUB;
      4'd2:    return AL_AND;
      4'd3:    return AL_OR;
      4'd4:    return AL_SLT;
      default: return AL_ADD;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (op)
      AL_SUB:  return a - b;
      AL_AND:  return a & b;
      AL_OR:   return a | b;
      AL_SLT:  return ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
      default: return a + b;
    endcase
  endfunction

endpackage

// File: rtl/mcpu_alu.sv
module mcpu_alu
  import mcpu_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  assign y = alu_eval(op, a, b);
endmodule

// File: rtl/mcpu_regfile.sv
module mcpu_regfile
  import mcpu_pkg::*;
#(
  parameter int N = NREG,
  parameter int W = XLEN,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] bank [N];

  // entry 0 is cleared at reset and never written afterwards (R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) bank[i] <= '0;
    end else begin
      for (int i = 1; i < N; i++)
        if (we && wa == AW'(i)) bank[i] <= wd;
    end
  end

  assign rd1 = bank[ra1];
  assign rd2 = bank[ra2];

  a_r10_zero_reg_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ra1 == '0) |-> (rd1 == '0));
endmodule

// File: rtl/mcpu_mem.sv
module mcpu_mem
  import mcpu_pkg::*;
#(
  parameter int DEPTH = 255,
  parameter int LDAW  = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_we,
  input  logic [LDAW-1:0] ld_addr,
  input  logic [XLEN-1:0] ld_data,
  input  logic            st_we,
  input  logic [XLEN-1:0] st_addr,
  input  logic [XLEN-1:0] st_data,
  input  logic [XLEN-1:0] rd_addr,
  output logic [XLEN-1:0] rd_data,
  output logic [XLEN-1:0] disp
);
  logic [XLEN-1:0] words [DEPTH];
  logic ld_hit, st_hit, rd_hit;

  assign ld_hit = ld_we && (32'(ld_addr) < DEPTH);
  assign st_hit = st_we && (32'(st_addr) < DEPTH);
  assign rd_hit = 32'(rd_addr) < DEPTH;

  // load port wins over the core store (R12)
  always_ff @(posedge clk) begin
    if (ld_hit)      words[ld_addr[IW-1:0]] <= ld_data;
    else if (st_hit) words[st_addr[IW-1:0]] <= st_data;
  end

  assign rd_data = rd_hit ? words[rd_addr[IW-1:0]] : '0;
  assign disp    = words[DEPTH-1];

  a_r11_display_follows_store: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && !ld_we && st_addr == XLEN'(DEPTH-1)) |=> (disp == $past(st_data)));
endmodule

// File: rtl/mcpu_ctrl.sv
module mcpu_ctrl
  import mcpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] op,
  input  logic [3:0] fn,
  input  logic       operands_equal,
  output ctrl_t      c,
  output state_e     state
);
  state_e st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_FETCH;
    else        st_q <= st_d;
  end

  always_comb begin
    c    = '0;
    st_d = st_q;
    case (st_q)
      ST_FETCH: begin
        c.ir_ld   = 1'b1;
        c.pc_ld   = 1'b1;
        c.a_is_pc = 1'b1;
        c.bsel    = BS_ONE;
        c.aop     = AL_ADD;
        st_d      = ST_DECODE;
      end
      ST_DECODE: begin
        c.ab_ld = 1'b1;
        st_d    = ST_EXEC;
      end
      ST_EXEC: begin
        st_d = ST_FETCH;
        case (op)
          OP_RTYPE: begin
            c.bsel      = BS_REG;
            c.aop       = funct_to_alu(fn);
            c.rf_we     = funct_valid(fn);
            c.rf_dst_rd = 1'b1;
          end
          OP_LOAD, OP_STORE: begin
            c.bsel  = BS_IMM;
            c.aop   = AL_ADD;
            c.ea_ld = 1'b1;
            st_d    = ST_MEM;
          end
          OP_BEQ: begin
            c.a_is_pc = 1'b1;
            c.bsel    = BS_IMM;
            c.aop     = AL_ADD;
            c.pc_ld   = operands_equal;
          end
          OP_ADDI: begin
            c.bsel  = BS_IMM;
            c.aop   = AL_ADD;
            c.rf_we = 1'b1;
          end
          OP_JUMP: begin
            c.pc_ld   = 1'b1;
            c.pc_jump = 1'b1;
          end
          OP_HALT: st_d = ST_HALT;
          default: st_d = ST_FETCH;
        endcase
      end
      ST_MEM: begin
        c.addr_ea = 1'b1;
        if (op == OP_LOAD) begin
          c.rf_we       = 1'b1;
          c.rf_from_mem = 1'b1;
        end else begin
          c.st_we = 1'b1;
        end
        st_d = ST_FETCH;
      end
      default: st_d = ST_HALT;
    endcase
  end

  assign state = st_q;

  a_r3_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FETCH) |=> (st_q == ST_DECODE));
  a_r6_mem_step_only_ldst: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MEM) |-> (op == OP_LOAD || op == OP_STORE));
endmodule

// File: rtl/mcpu16_core.sv
module mcpu16_core
  import mcpu_pkg::*;
#(
  parameter int DEPTH = 255,
  parameter int LDAW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_we,
  input  logic [LDAW-1:0] prog_addr,
  input  logic [XLEN-1:0] prog_data,
  output logic [XLEN-1:0] display_o,
  output logic [XLEN-1:0] pc_o,
  output logic            halted_o
);
  ctrl_t  c;
  state_e state;

  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, ea_q;
  logic [XLEN-1:0] alu_a, alu_b, alu_y, imm, mem_q, rf_rd1, rf_rd2, rf_wd;
  logic [RAW-1:0]  rf_wa;
  logic            operands_equal;
  logic            fetch_fire;

  assign imm            = sext_off(f_off(ir_q));
  assign operands_equal = (a_q == b_q);
  assign fetch_fire     = (state == ST_FETCH);

  mcpu_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .op             (f_op(ir_q)),
    .fn             (f_fn(ir_q)),
    .operands_equal (operands_equal),
    .c              (c),
    .state          (state)
  );

  assign alu_a = c.a_is_pc ? pc_q : a_q;
  always_comb begin
    case (c.bsel)
      BS_ONE:  alu_b = XLEN'(1);
      BS_IMM:  alu_b = imm;
      default: alu_b = b_q;
    endcase
  end

  mcpu_alu u_alu (
    .op (c.aop),
    .a  (alu_a),
    .b  (alu_b),
    .y  (alu_y)
  );

  assign rf_wa = c.rf_dst_rd ? f_rd(ir_q) : f_rt(ir_q);
  assign rf_wd = c.rf_from_mem ? mem_q : alu_y;

  mcpu_regfile u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (f_rs(ir_q)),
    .ra2   (f_rt(ir_q)),
    .rd1   (rf_rd1),
    .rd2   (rf_rd2),
    .we    (c.rf_we),
    .wa    (rf_wa),
    .wd    (rf_wd)
  );

  mcpu_mem #(.DEPTH(DEPTH), .LDAW(LDAW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_we   (prog_we),
    .ld_addr (prog_addr),
    .ld_data (prog_data),
    .st_we   (c.st_we),
    .st_addr (ea_q),
    .st_data (b_q),
    .rd_addr (c.addr_ea ? ea_q : pc_q),
    .rd_data (mem_q),
    .disp    (display_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      ea_q <= '0;
    end else begin
      if (c.pc_ld) pc_q <= c.pc_jump ? XLEN'(f_tgt(ir_q)) : alu_y;
      if (c.ir_ld) ir_q <= mem_q;
      if (c.ab_ld) begin
        a_q <= rf_rd1;
        b_q <= rf_rd2;
      end
      if (c.ea_ld) ea_q <= alu_y;
    end
  end

  assign pc_o     = pc_q;
  assign halted_o = (state == ST_HALT);

  a_r2_pc_step_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fire |=> (pc_q == $past(pc_q) + XLEN'(1)));
  a_r2_ir_only_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_fire |=> $stable(ir_q));
  a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> (halted_o && $stable(pc_q)));
endmodule

// File: tb/mcpu16_core_test.sv
`timescale 1ns/1ps
module mcpu16_core_test;
  localparam int DEPTH = 255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [7:0]  prog_addr = '0;
  logic [15:0] prog_data = '0;
  logic [15:0] display_o, pc_o;
  logic        halted_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  mcpu16_core uut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .display_o(display_o), .pc_o(pc_o), .halted_o(halted_o)
  );

  // ---------------- encoders (R4 field positions) ----------------
  function automatic logic [15:0] enc_r(int fn, int rs, int rt, int rd);
    return {3'd0, 3'(rs), 3'(rt), 3'(rd), 4'(fn)};
  endfunction
  function automatic logic [15:0] enc_i(int op, int rs, int rt, int off);
    return {3'(op), 3'(rs), 3'(rt), 7'(off)};
  endfunction
  function automatic logic [15:0] enc_j(int op, int tgt);
    return {3'(op), 13'(tgt)};
  endfunction

  // ---------------- behavioural reference ----------------
  logic [15:0] mm [256];
  logic [15:0] rr [8];
  logic [15:0] m_pc, m_ir, m_a, m_b, m_ea;
  int          phase;   // 0 fetch, 1 decode, 2 execute, 3 memory, 4 halted

  function automatic logic [15:0] m_read(logic [15:0] adr);
    return (adr < 16'(DEPTH)) ? mm[adr[7:0]] : 16'h0;   // R6: out of range reads zero
  endfunction

  function automatic logic [15:0] sx(logic [6:0] v);
    return {{9{v[6]}}, v};                            // R9
  endfunction

  task automatic m_step();
    logic [2:0] op;
    logic [3:0] fn;
    logic [15:0] r;
    op = m_ir[15:13];
    fn = m_ir[3:0];
    case (phase)
      0: begin m_ir = m_read(m_pc); m_pc = m_pc + 16'd1; phase = 1; end  // R2
      1: begin m_a = rr[m_ir[12:10]]; m_b = rr[m_ir[9:7]]; phase = 2; end
      2: begin
        phase = 0;                                                        // R3
        case (op)
          3'd0: begin                                                     // R5
            case (fn)
              4'd0: r = m_a + m_b;
              4'd1: r = m_a - m_b;
              4'd2: r = m_a & m_b;
              4'd3: r = m_a | m_b;
              default: r = ($signed(m_a) < $signed(m_b)) ? 16'd1 : 16'd0;
            endcase
            if (fn <= 4'd4 && m_ir[6:4] != 3'd0) rr[m_ir[6:4]] = r;       // R10
          end
          3'd1, 3'd2: begin m_ea = m_a + sx(m_ir[6:0]); phase = 3; end
          3'd3: if (m_a == m_b) m_pc = m_pc + sx(m_ir[6:0]);              // R7
          3'd4: if (m_ir[9:7] != 3'd0) rr[m_ir[9:7]] = m_a + sx(m_ir[6:0]);
          3'd5: m_pc = {3'd0, m_ir[12:0]};                                // R7
          3'd7: phase = 4;                                                // R8
          default: ;                                                      // R13
        endcase
      end
      3: begin
        if (op == 3'd1) begin
          if (m_ir[9:7] != 3'd0) rr[m_ir[9:7]] = m_read(m_ea);            // R6
        end else if (!prog_we && m_ea < 16'(DEPTH)) begin
          mm[m_ea[7:0]] = m_b;                                            // R12
        end
        phase = 0;
      end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = '0; m_ir = '0; m_a = '0; m_b = '0; m_ea = '0; phase = 0;
      for (int i = 0; i < 8; i++) rr[i] = '0;
    end else begin
      m_step();
    end
    if (prog_we && prog_addr < 8'(DEPTH)) mm[prog_addr] = prog_data;
  end

  task automatic check16(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check16("R2", "pc", pc_o, m_pc);
      check16("R8", "halted", {15'd0, halted_o}, {15'd0, phase == 4});
      check16("R11", "display", display_o, mm[254]);
    end
  end

  // ---------------- program ----------------
  logic [15:0] prog [29];
  initial begin
    prog[0]  = enc_i(4, 0, 7, 63);
    prog[1]  = enc_r(0, 7, 7, 7);
    prog[2]  = enc_r(0, 7, 7, 7);
    prog[3]  = enc_i(4, 7, 7, 2);       // r7 = 254
    prog[4]  = enc_i(4, 0, 1, 5);
    prog[5]  = enc_i(4, 0, 2, -3);
    prog[6]  = enc_r(0, 1, 2, 3);       // add
    prog[7]  = enc_i(2, 7, 3, 0);
    prog[8]  = enc_r(1, 2, 1, 3);       // sub
    prog[9]  = enc_i(2, 7, 3, 0);
    prog[10] = enc_r(2, 1, 2, 3);       // and
    prog[11] = enc_r(3, 1, 2, 3);       // or
    prog[12] = enc_i(2, 7, 3, 0);
    prog[13] = enc_r(4, 2, 1, 3);       // slt -3<5
    prog[14] = enc_i(2, 7, 3, 0);
    prog[15] = enc_r(9, 1, 2, 3);       // invalid funct: no write
    prog[16] = enc_i(1, 0, 5, 40);      // lw r5, 40(r0)
    prog[17] = enc_i(2, 7, 5, 0);
    prog[18] = enc_i(3, 1, 1, 2);       // beq taken -> 21
    prog[19] = enc_i(4, 0, 6, 1);
    prog[20] = enc_i(2, 7, 6, 0);
    prog[21] = enc_i(3, 1, 2, 5);       // beq not taken
    prog[22] = enc_j(5, 24);
    prog[23] = enc_j(7, 0);
    prog[24] = enc_i(4, 0, 0, 9);       // write to r0 discarded
    prog[25] = enc_i(2, 7, 0, 0);
    prog[26] = enc_i(4, 0, 6, -64);
    prog[27] = enc_i(2, 7, 6, 0);
    prog[28] = {3'd6, 13'd0};           // R13 op 6 is a no-op ... then halt below
  end

  task automatic load_word(int a, logic [15:0] d);
    prog_we = 1'b1; prog_addr = 8'(a); prog_data = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    check16("R1", "pc in reset", pc_o, 16'h0);
    check16("R1", "halted in reset", {15'd0, halted_o}, 16'h0);
    for (int a = 0; a < DEPTH; a++) begin
      logic [15:0] w;
      w = 16'h0;
      if (a < 29) w = prog[a];
      if (a == 29) w = enc_j(7, 0);
      if (a == 40) w = 16'h1234;
      load_word(a, w);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3000 && !halted_o; i++) @(negedge clk);
    if (!halted_o) begin
      n_tests++; n_fail++;
      $display("FAIL R8 watchdog: actual running expected halted");
    end
    check16("R9", "final display", display_o, 16'hFFC0);
    check16("R8", "pc after halt", pc_o, 16'd30);
    for (int i = 0; i < 20; i++) @(negedge clk);
    check16("R8", "pc frozen", pc_o, 16'd30);
    // R12: load port after halt updates display word
    load_word(254, 16'hBEEF);
    check16("R12", "display after load", display_o, 16'hBEEF);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200us;
    n_tests++; n_fail++;
    $display("FAIL R8 global timeout: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule